// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Condition Flags

This block is a purely combinational 64-bit arithmetic/logic unit. Two operand words, X and Y, and a 2-bit function select go in. One result word comes out, along with three condition flags: signed overflow, zero and carry. The select picks one of four operations: add, subtract, bitwise AND and bitwise XOR. The block has no clock and holds no state, so the outputs follow the inputs continuously.

The unit computes the flags for every operation alongside the result. A condition register outside the block can latch them whenever a later stage needs them. All four select codes are defined, so no input value is illegal.

Top module: `alu_flags`

## Requirements
- R1: With select code 0, the result is X + Y modulo 2^64.
- R2: With select code 1, the result is X - Y modulo 2^64.
- R3: With select code 2, the result is the bitwise AND of X and Y.
- R4: With select code 3, the result is the bitwise XOR of X and Y.
- R5: The zero flag is 1 exactly when all 64 result bits are 0. This holds for every select code.
- R6: With code 0, the overflow flag is 1 exactly when X and Y have the same sign bit (bit 63) and the result's sign bit differs from it.
- R7: With code 1, the overflow flag is 1 exactly when X and Y have different sign bits and the result's sign bit differs from that of X.
- R8: With code 0, the carry flag is the carry out of bit 63 of the unsigned sum.
- R9: With code 1, the carry flag is 1 exactly when Y, read as unsigned, is greater than X (a borrow).
- R10: With codes 2 and 3, the overflow and carry flags are both 0.
- R11: The outputs settle to the values for the current inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_x | input | 64 | First operand X |
| op_y | input | 64 | Second operand Y |
| func | input | 2 | Operation select: 0 add, 1 subtract, 2 AND, 3 XOR |
| result | output | 64 | Result word |
| flag_of | output | 1 | Signed overflow |
| flag_zf | output | 1 | Result is zero |
| flag_cf | output | 1 | Unsigned carry out (add) or borrow (subtract) |

## Verification
Operands sit exactly at the signed and unsigned limits. These vectors separate the overflow rule from the carry rule. The all-ones plus one case carries without overflowing. The largest positive plus one overflows without carrying. The most negative plus itself does both and also gives a zero result. For subtraction, equal operands, zero minus one and both signs crossing the limit tell borrow apart from signed overflow. Random operands for every code, including identical and complementary pairs for the logic codes, catch a wrong operation mapping and flags that leak into AND and XOR.

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W = 64
) (
  input  logic [W-1:0] op_x,
  input  logic [W-1:0] op_y,
  input  logic [1:0]   func,
  output logic [W-1:0] result,
  output logic         flag_of,
  output logic         flag_zf,
  output logic         flag_cf
);
  localparam int MSB = W - 1;

  logic [W:0] sum_ext;
  logic [W:0] dif_ext;
  logic       add_ovf;
  logic       sub_ovf;

  assign sum_ext = {1'b0, op_x} + {1'b0, op_y};
  assign dif_ext = {1'b0, op_x} - {1'b0, op_y};

  assign add_ovf = (op_x[MSB] == op_y[MSB]) && (sum_ext[MSB] != op_x[MSB]);
  assign sub_ovf = (op_x[MSB] != op_y[MSB]) && (dif_ext[MSB] != op_x[MSB]);

  always_comb begin
    result  = '0;
    flag_of = 1'b0;
    flag_cf = 1'b0;
    unique case (func)
      2'd0: begin
        result  = sum_ext[W-1:0];
        flag_of = add_ovf;
        flag_cf = sum_ext[W];
      end
      2'd1: begin
        result  = dif_ext[W-1:0];
        flag_of = sub_ovf;
        flag_cf = dif_ext[W];
      end
      2'd2: result = op_x & op_y;
      default: result = op_x ^ op_y;
    endcase
  end

  assign flag_zf = ~|result;
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk #(
  parameter int W = 64
) (
  input logic [W-1:0] op_x,
  input logic [W-1:0] op_y,
  input logic [1:0]   func,
  input logic [W-1:0] result,
  input logic         flag_of,
  input logic         flag_zf,
  input logic         flag_cf
);
  always_comb begin
    if (!$isunknown({op_x, op_y, func, result})) begin
      p_zero_flag_r5: assert (flag_zf == (result == '0));
      if (func == 2'd0)
        p_add_inverse_r1: assert (result - op_y == op_x);
      if (func == 2'd1)
        p_sub_inverse_r2: assert (result + op_y == op_x);
      if (func == 2'd2)
        p_and_subset_r3: assert (((result & ~op_x) == '0) && ((result & ~op_y) == '0));
      if (func == 2'd3)
        p_xor_undo_r4: assert ((result ^ op_y) == op_x);
      if (func[1])
        p_logic_no_flags_r10: assert (!flag_of && !flag_cf);
      if (func == 2'd1)
        p_borrow_r9: assert (flag_cf == (op_y > op_x));
    end
  end
endmodule

bind alu_flags alu_flags_chk #(.W(W)) u_chk (
  .op_x(op_x), .op_y(op_y), .func(func), .result(result),
  .flag_of(flag_of), .flag_zf(flag_zf), .flag_cf(flag_cf)
);

// File: tb/sim_alu_flags.sv
module sim_alu_flags;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] op_x = '0;
  logic [63:0] op_y = '0;
  logic [1:0]  func = 2'd0;
  logic [63:0] result;
  logic        flag_of, flag_zf, flag_cf;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  alu_flags u0 (
    .op_x(op_x), .op_y(op_y), .func(func),
    .result(result), .flag_of(flag_of), .flag_zf(flag_zf), .flag_cf(flag_cf)
  );

  task automatic check1(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (x=%h y=%h f=%0d)",
               req, what, act, exp, op_x, op_y, func);
    end
  endtask

  task automatic apply(input logic [63:0] x, input logic [63:0] y, input logic [1:0] f);
    logic signed [64:0] s_ext;
    logic [64:0]        u_ext;
    logic [63:0]        e_res;
    bit                 e_of, e_cf;
    string              r_res, r_of, r_cf;
    @(posedge clk);
    #1;
    op_x = x; op_y = y; func = f;
    case (f)
      2'd0: begin
        u_ext = {1'b0, x} + {1'b0, y};
        s_ext = $signed({x[63], x}) + $signed({y[63], y});
        e_res = u_ext[63:0];
        e_cf  = u_ext[64];
        e_of  = (s_ext > 65'sh0_7FFF_FFFF_FFFF_FFFF) || (s_ext < -65'sh0_8000_0000_0000_0000);
        r_res = "R1"; r_of = "R6"; r_cf = "R8";
      end
      2'd1: begin
        s_ext = $signed({x[63], x}) - $signed({y[63], y});
        e_res = x - y;
        e_cf  = (y > x);
        e_of  = (s_ext > 65'sh0_7FFF_FFFF_FFFF_FFFF) || (s_ext < -65'sh0_8000_0000_0000_0000);
        r_res = "R2"; r_of = "R7"; r_cf = "R9";
      end
      2'd2: begin
        e_res = x & y; e_of = 0; e_cf = 0;
        r_res = "R3"; r_of = "R10"; r_cf = "R10";
      end
      default: begin
        e_res = x ^ y; e_of = 0; e_cf = 0;
        r_res = "R4"; r_of = "R10"; r_cf = "R10";
      end
    endcase
    @(negedge clk);
    // R11: inputs changed after the rising edge; sampled before the next one
    check1(r_res, "result", result, e_res);
    check1("R5", "zf", {63'd0, flag_zf}, {63'd0, (e_res == 64'd0)});
    check1(r_of, "of", {63'd0, flag_of}, {63'd0, e_of});
    check1(r_cf, "cf", {63'd0, flag_cf}, {63'd0, e_cf});
  endtask

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] SMAX = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] SMIN = 64'h8000_0000_0000_0000;

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check1("R5", "initial zf", {63'd0, flag_zf}, 64'd1);
    check1("R1", "initial result", result, 64'd0);
    apply(ONES, 64'd1, 2'd0);
    apply(SMAX, 64'd1, 2'd0);
    apply(SMIN, SMIN, 2'd0);
    apply(SMIN, ONES, 2'd0);
    apply(64'd5, 64'd7, 2'd0);
    apply(64'd0, 64'd1, 2'd1);
    apply(SMIN, 64'd1, 2'd1);
    apply(SMAX, ONES, 2'd1);
    apply(64'h1234, 64'h1234, 2'd1);
    apply(ONES, SMAX, 2'd1);
    apply(ONES, ONES, 2'd2);
    apply(SMIN, SMAX, 2'd2);
    apply(ONES, ONES, 2'd3);
    apply(SMIN, SMAX, 2'd3);
    for (int i = 0; i < 800; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = (i % 7 == 0) ? a : ((i % 11 == 0) ? ~a : {$urandom, $urandom});
      apply(a, b, 2'(i % 4));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule